// File: doc/BRIEF.md
# DRAM Open-Page Tracker

The tracker holds, for every bank of every rank, whether a row is open and which row that is. Each access offered on the lookup port (rank, bank, row) is compared with that table. The access is sorted into one of three cases: the same row is already open (page hit), the bank is closed (idle miss), or the bank holds a different row (page conflict). The result also gives the preparatory commands the next stage must send before the column command: nothing, an activate, or a precharge followed by an activate.

The table never changes because of a lookup. It changes only when the command stage reports a command it has actually sent: an activate opens a row, a bank precharge closes one bank, and a precharge-all or a refresh closes every bank of one rank. A report and a lookup that hit the same bank in the same cycle are resolved by bypass, so the lookup is classified against the table as it stands after the report. Results leave through one register stage with a valid/ready handshake.

Top module: `open_page_tracker`

## Requirements
- R1: After reset every bank of every rank is closed, `out_valid` is 0 and `req_ready` is 1. A first lookup of any bank gives the idle-miss class (`out_cls` = 2'b01) and `out_need` = 2'b01.
- R2: Reporting an activate (`upd_cmd` = 3'd1) for a rank, bank and row opens that row. A later lookup of the same rank, bank and row gives the hit class (`out_cls` = 2'b00) and `out_need` = 2'b00.
- R3: A lookup of an open bank with a different row gives the conflict class (`out_cls` = 2'b10) and `out_need` = 2'b11. In `out_need`, bit 1 means precharge and bit 0 means activate.
- R4: Reporting a bank precharge (`upd_cmd` = 3'd2) closes only the addressed bank of the addressed rank. Every other bank keeps its open row.
- R5: Reporting a precharge-all (`upd_cmd` = 3'd3) closes every bank of the addressed rank. Banks of the other rank are unchanged.
- R6: Reporting a refresh (`upd_cmd` = 3'd4) closes every bank of the addressed rank in the same way as R5. Banks of the other rank are unchanged.
- R7: Each rank/bank pair holds its own entry. The same bank number in two ranks can be open on different rows at the same time.
- R8: A lookup never changes the table. Repeating a lookup, including one that gave a conflict, gives the same result.
- R9: When a report and a lookup arrive in the same cycle, the lookup is classified against the table after the report has been applied.
- R10: A lookup accepted on a rising edge, when `req_valid` and `req_ready` are both 1, shows its result on `out_valid`, `out_cls` and `out_need` from that edge on. While `out_ready` is 0 the result holds, and `req_ready` equals `!out_valid || out_ready`.
- R11: A report of `upd_cmd` = 3'd0 (no command) leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_rank | input | RANK_W | Lookup rank |
| req_bank | input | BANK_W | Lookup bank |
| req_row | input | ROW_W | Lookup row |
| upd_cmd | input | 3 | Issued command report: 0 none, 1 activate, 2 precharge, 3 precharge-all, 4 refresh |
| upd_rank | input | RANK_W | Rank of reported command |
| upd_bank | input | BANK_W | Bank of reported activate or precharge |
| upd_row | input | ROW_W | Row of reported activate |
| out_valid | output | 1 | Classification result present |
| out_ready | input | 1 | Downstream takes the result |
| out_cls | output | 2 | 00 hit, 01 idle miss, 10 conflict |
| out_need | output | 2 | Bit 1 precharge needed, bit 0 activate needed |

## Verification
A wrong table entry shows at the ports only when that bank is next looked up. The fault appears on the edge that accepts the lookup, as a hit where a miss belongs or the reverse. For that reason the bench looks up every bank it has touched, and its neighbours, directly after each report. A dropped bypass shows one cycle earlier than a stale table. It is caught by driving a report and a lookup of the same bank together and checking the result on the very next edge.

// File: rtl/opt_pkg.sv
package opt_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_ACT    = 3'd1,
        CMD_PRE    = 3'd2,
        CMD_PREALL = 3'd3,
        CMD_REF    = 3'd4
    } upd_cmd_e;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'b00,
        CLS_IDLE     = 2'b01,
        CLS_CONFLICT = 2'b10
    } page_cls_e;

    // bit 1: precharge, bit 0: activate
    localparam logic [1:0] NEED_NONE    = 2'b00;
    localparam logic [1:0] NEED_ACT     = 2'b01;
    localparam logic [1:0] NEED_PRE_ACT = 2'b11;

endpackage

// File: rtl/opt_bank_table.sv
module opt_bank_table
    import opt_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    localparam int IDX_W = RANK_W + BANK_W,
    localparam int NB    = 1 << BANK_W,
    localparam int NR    = 1 << RANK_W,
    localparam int NE    = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   upd_cmd,
    input  logic [RANK_W-1:0]            upd_rank,
    input  logic [BANK_W-1:0]            upd_bank,
    input  logic [ROW_W-1:0]             upd_row,
    output logic [NE-1:0]                vld_nx,
    output logic [NE-1:0][ROW_W-1:0]     row_nx
);

    typedef struct packed {
        logic [NE-1:0]            vld;
        logic [NE-1:0][ROW_W-1:0] row;
    } tbl_t;

    tbl_t tb_d, tb_q;
    logic [IDX_W-1:0] uidx;

    assign uidx = {upd_rank, upd_bank};

    always_comb begin
        tb_d = tb_q;
        case (upd_cmd)
            CMD_ACT: begin
                tb_d.vld[uidx] = 1'b1;
                tb_d.row[uidx] = upd_row;
            end
            CMD_PRE: begin
                tb_d.vld[uidx] = 1'b0;
            end
            CMD_PREALL, CMD_REF: begin
                for (int b = 0; b < NB; b++) begin
                    tb_d.vld[{upd_rank, BANK_W'(b)}] = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    // lookups read the post-update view (bypass)
    assign vld_nx = tb_d.vld;
    assign row_nx = tb_d.row;

    // R2: an activate report leaves the addressed entry open on its row
    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cmd == CMD_ACT) |=> (tb_q.vld[$past(uidx)] && tb_q.row[$past(uidx)] == $past(upd_row)));

    // R4: a bank precharge report closes the addressed entry
    a_r4_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cmd == CMD_PRE) |=> !tb_q.vld[$past(uidx)]);

    // R11: a no-command report leaves the table as it was
    a_r11_none_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cmd == CMD_NONE) |=> ($stable(tb_q.vld) && $stable(tb_q.row)));

    generate
        for (genvar r = 0; r < NR; r++) begin : g_rank_chk
            // R5, R6: precharge-all and refresh close the whole rank
            a_r5_rank_closed: assert property (@(posedge clk) disable iff (!rst_n)
                ((upd_cmd == CMD_PREALL || upd_cmd == CMD_REF) && upd_rank == RANK_W'(r))
                |=> (tb_q.vld[r*NB +: NB] == '0));
        end
    endgenerate

endmodule

// File: rtl/opt_classify.sv
module opt_classify
    import opt_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    localparam int IDX_W = RANK_W + BANK_W,
    localparam int NE    = 1 << IDX_W
) (
    input  logic [NE-1:0]            vld_nx,
    input  logic [NE-1:0][ROW_W-1:0] row_nx,
    input  logic [RANK_W-1:0]        lk_rank,
    input  logic [BANK_W-1:0]        lk_bank,
    input  logic [ROW_W-1:0]         lk_row,
    output page_cls_e                cls,
    output logic [1:0]               need
);

    logic [IDX_W-1:0] idx;
    assign idx = {lk_rank, lk_bank};

    always_comb begin
        if (!vld_nx[idx]) begin
            cls  = CLS_IDLE;
            need = NEED_ACT;
        end else if (row_nx[idx] == lk_row) begin
            cls  = CLS_HIT;
            need = NEED_NONE;
        end else begin
            cls  = CLS_CONFLICT;
            need = NEED_PRE_ACT;
        end
    end

endmodule

// File: rtl/open_page_tracker.sv
module open_page_tracker
    import opt_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    localparam int NE    = 1 << (RANK_W + BANK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [2:0]        upd_cmd,
    input  logic [RANK_W-1:0] upd_rank,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_cls,
    output logic [1:0]        out_need
);

    typedef struct packed {
        logic       vld;
        page_cls_e  cls;
        logic [1:0] need;
    } out_t;

    logic [NE-1:0]            vld_nx;
    logic [NE-1:0][ROW_W-1:0] row_nx;
    page_cls_e                cls_w;
    logic [1:0]               need_w;
    logic                     accept;
    out_t                     o_d, o_q;

    opt_bank_table #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_cmd  (upd_cmd),
        .upd_rank (upd_rank),
        .upd_bank (upd_bank),
        .upd_row  (upd_row),
        .vld_nx   (vld_nx),
        .row_nx   (row_nx)
    );

    opt_classify #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_cls (
        .vld_nx  (vld_nx),
        .row_nx  (row_nx),
        .lk_rank (req_rank),
        .lk_bank (req_bank),
        .lk_row  (req_row),
        .cls     (cls_w),
        .need    (need_w)
    );

    assign req_ready = !o_q.vld || out_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        o_d = o_q;
        if (accept) begin
            o_d.vld  = 1'b1;
            o_d.cls  = cls_w;
            o_d.need = need_w;
        end else if (out_ready) begin
            o_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_cls   = o_q.cls;
    assign out_need  = o_q.need;

    // R10: a stalled result holds until taken
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_cls) && $stable(out_need)));

    // R3: a precharge is never requested without the activate after it
    a_r3_pre_implies_act: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_need != 2'b10));

endmodule

// File: tb/sim_open_page_tracker.sv
`timescale 1ns/1ps
module sim_open_page_tracker;

    localparam int RANK_W = 1;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 14;

    localparam logic [1:0] HIT = 2'b00, IDLE = 2'b01, CONF = 2'b10;
    localparam logic [1:0] N_NONE = 2'b00, N_ACT = 2'b01, N_PA = 2'b11;
    localparam logic [2:0] C_NONE = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_PALL = 3'd3, C_REF = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [RANK_W-1:0] req_rank = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [2:0]        upd_cmd = 3'd0;
    logic [RANK_W-1:0] upd_rank = '0;
    logic [BANK_W-1:0] upd_bank = '0;
    logic [ROW_W-1:0]  upd_row = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [1:0] out_cls;
    logic [1:0] out_need;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    open_page_tracker #(.RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
        .upd_cmd(upd_cmd), .upd_rank(upd_rank), .upd_bank(upd_bank), .upd_row(upd_row),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_cls(out_cls), .out_need(out_need)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic look(input int rk, input int bk, input int row,
                        input logic [1:0] ec, input logic [1:0] en, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_rank = RANK_W'(rk); req_bank = BANK_W'(bk); req_row = ROW_W'(row);
        out_ready = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " valid"}, 16'(out_valid), 16'd1);
        chk(out_cls == ec, {tag, " class"}, 16'(out_cls), 16'(ec));
        chk(out_need == en, {tag, " need"}, 16'(out_need), 16'(en));
    endtask

    task automatic report(input logic [2:0] cmd, input int rk, input int bk, input int row);
        @(negedge clk);
        upd_cmd = cmd; upd_rank = RANK_W'(rk); upd_bank = BANK_W'(bk); upd_row = ROW_W'(row);
        @(posedge clk); #1;
        upd_cmd = C_NONE;
    endtask

    task automatic both(input logic [2:0] cmd, input int rk, input int bk, input int urow, input int lrow,
                        input logic [1:0] ec, input logic [1:0] en, input string tag);
        @(negedge clk);
        upd_cmd = cmd; upd_rank = RANK_W'(rk); upd_bank = BANK_W'(bk); upd_row = ROW_W'(urow);
        req_valid = 1'b1; req_rank = RANK_W'(rk); req_bank = BANK_W'(bk); req_row = ROW_W'(lrow);
        out_ready = 1'b1;
        @(posedge clk); #1;
        upd_cmd = C_NONE; req_valid = 1'b0;
        chk(out_cls == ec, {tag, " class"}, 16'(out_cls), 16'(ec));
        chk(out_need == en, {tag, " need"}, 16'(out_need), 16'(en));
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 out_valid in reset", 16'(out_valid), 16'd0);
        chk(req_ready == 1'b1, "R10 req_ready in reset", 16'(req_ready), 16'd1);
        @(negedge clk); rst_n = 1'b1;
        look(0, 0, 5, IDLE, N_ACT, "R1 rank0 bank0");
        look(1, 3, 9, IDLE, N_ACT, "R1 rank1 bank3");
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R10 drains", 16'(out_valid), 16'd0);
    endtask

    task automatic t_hit_conflict;
        report(C_ACT, 0, 1, 'h123);
        look(0, 1, 'h123, HIT, N_NONE, "R2 hit");
        look(0, 1, 'h124, CONF, N_PA, "R3 conflict");
        look(0, 1, 'h123, HIT, N_NONE, "R8 unchanged after conflict");
        look(0, 1, 'h123, HIT, N_NONE, "R8 repeat");
    endtask

    task automatic t_ranks;
        look(1, 1, 'h123, IDLE, N_ACT, "R7 other rank closed");
        report(C_ACT, 1, 1, 'h200);
        look(0, 1, 'h123, HIT, N_NONE, "R7 rank0 row kept");
        look(1, 1, 'h200, HIT, N_NONE, "R7 rank1 row");
        look(1, 1, 'h123, CONF, N_PA, "R7 rank1 distinct");
    endtask

    task automatic t_precharge;
        report(C_ACT, 0, 2, 'h10);
        report(C_PRE, 0, 1, 0);
        look(0, 1, 'h123, IDLE, N_ACT, "R4 closed bank");
        look(0, 2, 'h10, HIT, N_NONE, "R4 neighbour kept");
        look(1, 1, 'h200, HIT, N_NONE, "R4 other rank kept");
    endtask

    task automatic t_none;
        report(C_NONE, 0, 2, 'h55);
        look(0, 2, 'h10, HIT, N_NONE, "R11 no-command ignored");
        look(0, 2, 'h55, CONF, N_PA, "R11 row not written");
    endtask

    task automatic t_preall;
        report(C_ACT, 0, 3, 7);
        report(C_PALL, 0, 0, 0);
        look(0, 2, 'h10, IDLE, N_ACT, "R5 bank2 closed");
        look(0, 3, 7, IDLE, N_ACT, "R5 bank3 closed");
        look(1, 1, 'h200, HIT, N_NONE, "R5 other rank kept");
    endtask

    task automatic t_refresh;
        report(C_ACT, 0, 0, 9);
        report(C_REF, 1, 0, 0);
        look(1, 1, 'h200, IDLE, N_ACT, "R6 rank1 closed");
        look(0, 0, 9, HIT, N_NONE, "R6 rank0 kept");
    endtask

    task automatic t_bypass;
        both(C_ACT, 1, 2, 'h77, 'h77, HIT, N_NONE, "R9 act bypass hit");
        both(C_PRE, 1, 2, 0, 'h77, IDLE, N_ACT, "R9 pre bypass idle");
        both(C_ACT, 1, 2, 'h78, 'h77, CONF, N_PA, "R9 act bypass conflict");
        both(C_REF, 1, 2, 0, 'h78, IDLE, N_ACT, "R9 refresh bypass");
        report(C_ACT, 1, 2, 'h78);
    endtask

    task automatic t_hold;
        @(negedge clk);
        req_valid = 1'b1; req_rank = 1'b1; req_bank = 2'd2; req_row = ROW_W'('h78);
        out_ready = 1'b0;
        @(posedge clk); #1;
        chk(out_cls == HIT, "R10 first result", 16'(out_cls), 16'(HIT));
        chk(req_ready == 1'b0, "R10 ready low when stalled", 16'(req_ready), 16'd0);
        @(negedge clk);
        req_row = ROW_W'('h79);
        @(posedge clk); #1;
        chk(out_valid == 1'b1, "R10 held valid", 16'(out_valid), 16'd1);
        chk(out_cls == HIT, "R10 held class", 16'(out_cls), 16'(HIT));
        chk(out_need == N_NONE, "R10 held need", 16'(out_need), 16'(N_NONE));
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(out_cls == CONF, "R10 next result", 16'(out_cls), 16'(CONF));
        chk(out_need == N_PA, "R10 next need", 16'(out_need), 16'(N_PA));
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R10 drained", 16'(out_valid), 16'd0);
    endtask

    initial begin
        t_reset;
        t_hit_conflict;
        t_ranks;
        t_precharge;
        t_none;
        t_preall;
        t_refresh;
        t_bypass;
        t_hold;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule